// File: doc/BRIEF.md
# Reset and Stop-Recovery Sequencer

This block decides how long a small microcontroller stays in reset once something has asked for a reset. Four events can start a sequence: power-on, brown-out, the external reset pin, and a wake-up from stop mode. For each event the block counts cycles of the internal oscillator. It then releases the core reset, and it releases the reset of the control registers only when that reset was asserted for the event. Counting happens only while the oscillator reports that it is ready. For power-on and brown-out, counting starts only once the trigger goes away.

A system reset is any reset other than a stop-mode wake-up. During a system reset the block pulls the shared reset pin low through an open-drain driver and pulses a strobe that returns the GPIOs to their default state. When the count expires the block stops driving the pin. If something outside is still holding the pin low, the core stays in reset until the pin is released.

A stop-mode wake-up is much shorter and leaves the control registers untouched. A one-hot cause register records which event started the most recent sequence. All inputs are assumed to be synchronous to the oscillator clock. The two option bits are assumed to be static while a sequence is running.

Top module: `rstseq_top`

## Requirements
- R1: After a brown-out trigger falls, or after a pin-triggered reset has started, `core_rst_o` stays high for exactly L+1 clock cycles when the oscillator is continuously ready. L is 68 with the crystal option clear. The final cycle is the one in which the block checks the pin level after releasing it.
- R2: After `por_i` falls, the hold is L+`POR_WAIT_CYC`+1 cycles. While `por_i` is high, all reset outputs are high and `cause_o` is 4'b0001.
- R3: With `xtal_en_i` set, L becomes 568 when `long_tmg_i` is 0 and 10068 when it is 1.
- R4: A one-cycle pulse on `stop_wake_i` while the core is running holds `core_rst_o` high for exactly 4 cycles. During that time `ctrl_rst_o` and `rst_pin_drv_low_o` stay low.
- R5: `ctrl_rst_o` is high for every cycle of a system reset in which `core_rst_o` is high, and never when `core_rst_o` is low.
- R6: While `osc_rdy_i` is low, the cycle count stays at zero. If the oscillator is not ready for the first g cycles after the trigger is released (g ≥ 1), the hold becomes L+g for a system reset and 4+g−1 for a stop wake-up.
- R7: If the pin is still held low from outside when the count expires, the block has already stopped driving it. `core_rst_o` stays high and falls one cycle after the pin goes high.
- R8: `rst_pin_drv_low_o` is high from the start of a system reset until the count expires, which is one cycle fewer than the core reset, and never during a stop wake-up.
- R9: `gpio_dflt_o` pulses for exactly one cycle when a system reset starts, and does not pulse for a stop wake-up.
- R10: `cause_o` is one-hot, with bit 0 for power-on, bit 1 for brown-out, bit 2 for pin and bit 3 for stop wake-up. It is loaded when a trigger is accepted and held until the next one.
- R11: A brown-out at any time restarts the sequence as a system reset. A new wake pulse during a stop wake-up restarts its count. A wake pulse during a system reset is ignored.
- R12: A low pin level is taken as a trigger only while the core is running, so the block's own drive never re-triggers it or changes the cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal oscillator clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| bor_i | input | 1 | Brown-out condition, active high |
| rst_pin_i | input | 1 | Sensed level of the shared reset pin (low = asserted) |
| stop_wake_i | input | 1 | Stop-mode wake-up pulse |
| osc_rdy_i | input | 1 | Internal oscillator ready |
| xtal_en_i | input | 1 | Crystal oscillator enabled option |
| long_tmg_i | input | 1 | Long crystal timing option |
| core_rst_o | output | 1 | Core reset |
| ctrl_rst_o | output | 1 | Control-register and peripheral reset |
| rst_pin_drv_low_o | output | 1 | Open-drain pull-down enable for the reset pin |
| gpio_dflt_o | output | 1 | One-cycle strobe returning GPIOs to default |
| cause_o | output | 4 | One-hot cause of the last sequence |

## Verification
The hardest situation to reach from the ports is the release check. The pin is read low at expiry because the block itself was driving it, and the block must then tell that apart from an outside device that is still holding the pin. The bench models the pin as a wired-AND of the block's drive and an external pull-down. It keeps the external pull-down low past the full count, then releases it on a chosen cycle and checks the exact cycle in which the core reset falls. Oscillator dropouts and retriggers in the middle of a sequence are placed on exact cycles by directed cases. Random runs then mix the trigger type, the option bits and the dropout length.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_HOLD    = 2'd1,
    ST_COUNT   = 2'd2,
    ST_PINWAIT = 2'd3
  } seq_state_e;

  localparam int CAUSE_W = 4;
  localparam int CZ_POR  = 0;
  localparam int CZ_BOR  = 1;
  localparam int CZ_PIN  = 2;
  localparam int CZ_STOP = 3;

  // Number of ready oscillator cycles to spend counting for one sequence.
  function automatic int hold_cycles(input logic stop_k, input logic xtal,
                                     input logic long_t, input logic por_x,
                                     input int base_c, input int xs_c,
                                     input int xl_c, input int stop_c,
                                     input int wait_c);
    int n;
    if (stop_k) return stop_c;
    n = xtal ? (long_t ? xl_c : xs_c) : base_c;
    if (por_x) n = n + wait_c;
    return n;
  endfunction

endpackage

// File: rtl/rstseq_cnt.sv
module rstseq_cnt #(
  parameter int CW = 14
) (
  input  logic          clk_i,
  input  logic          por_i,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          osc_rdy_i,
  input  logic [CW-1:0] limit_i,
  output logic [CW-1:0] cnt_o,
  output logic          done_o
);

  assign done_o = en_i && osc_rdy_i && (cnt_o == limit_i - CW'(1));

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      cnt_o <= '0;
    end else if (clr_i || !osc_rdy_i || done_o) begin
      cnt_o <= '0;
    end else if (en_i) begin
      cnt_o <= cnt_o + CW'(1);
    end
  end

endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
  import rstseq_pkg::*;
(
  input  logic               clk_i,
  input  logic               por_i,
  input  logic               sys_hit_i,
  input  logic               bor_i,
  input  logic               stop_hit_i,
  output logic [CAUSE_W-1:0] cause_o
);

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      cause_o <= CAUSE_W'(1) << CZ_POR;
    end else if (sys_hit_i) begin
      cause_o <= bor_i ? (CAUSE_W'(1) << CZ_BOR) : (CAUSE_W'(1) << CZ_PIN);
    end else if (stop_hit_i) begin
      cause_o <= CAUSE_W'(1) << CZ_STOP;
    end
  end

endmodule

// File: rtl/rstseq_ctl.sv
module rstseq_ctl
  import rstseq_pkg::*;
(
  input  logic       clk_i,
  input  logic       por_i,
  input  logic       bor_i,
  input  logic       pin_i,
  input  logic       stop_wake_i,
  input  logic       done_i,
  output seq_state_e state_o,
  output logic       sys_kind_o,
  output logic       por_ext_o,
  output logic       sys_hit_o,
  output logic       stop_hit_o,
  output logic       gpio_o
);

  seq_state_e state_n;
  logic       kind_n;
  logic       por_ext_n;
  logic       pin_hit;
  logic       start_sys;

  // The pin counts as a trigger only while running; in reset it is our own drive.
  assign pin_hit    = (state_o == ST_RUN) && !pin_i;
  assign sys_hit_o  = bor_i || pin_hit;
  assign stop_hit_o = stop_wake_i && !sys_hit_o &&
                      ((state_o == ST_RUN) || ((state_o == ST_COUNT) && !sys_kind_o));
  assign start_sys  = sys_hit_o && (state_o != ST_HOLD);

  always_comb begin
    state_n   = state_o;
    kind_n    = sys_kind_o;
    por_ext_n = por_ext_o;
    if (sys_hit_o) begin
      state_n   = ST_HOLD;
      kind_n    = 1'b1;
      por_ext_n = 1'b0;
    end else if (stop_hit_o) begin
      state_n   = ST_COUNT;
      kind_n    = 1'b0;
      por_ext_n = 1'b0;
    end else begin
      case (state_o)
        ST_HOLD:    state_n = ST_COUNT;
        ST_COUNT:   if (done_i) state_n = sys_kind_o ? ST_PINWAIT : ST_RUN;
        ST_PINWAIT: if (pin_i) state_n = ST_RUN;
        default:    state_n = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      state_o    <= ST_HOLD;
      sys_kind_o <= 1'b1;
      por_ext_o  <= 1'b1;
      gpio_o     <= 1'b1;
    end else begin
      state_o    <= state_n;
      sys_kind_o <= kind_n;
      por_ext_o  <= por_ext_n;
      gpio_o     <= start_sys;
    end
  end

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int BASE_CYC       = 68,
  parameter int XTAL_SHORT_CYC = 568,
  parameter int XTAL_LONG_CYC  = 10068,
  parameter int STOP_CYC       = 4,
  parameter int POR_WAIT_CYC   = 1000
) (
  input  logic         clk_i,
  input  logic         por_i,
  input  logic         bor_i,
  input  logic         rst_pin_i,
  input  logic         stop_wake_i,
  input  logic         osc_rdy_i,
  input  logic         xtal_en_i,
  input  logic         long_tmg_i,
  output logic         core_rst_o,
  output logic         ctrl_rst_o,
  output logic         rst_pin_drv_low_o,
  output logic         gpio_dflt_o,
  output logic [3:0]   cause_o
);

  localparam int CW = $clog2(XTAL_LONG_CYC + POR_WAIT_CYC + 1);

  seq_state_e    st;
  logic          sys_kind;
  logic          por_ext;
  logic          sys_hit;
  logic          stop_hit;
  logic          cnt_done;
  logic          cnt_clr;
  logic          cnt_en;
  logic [CW-1:0] cnt_val;
  logic [CW-1:0] hold_lim;

  assign hold_lim = CW'(hold_cycles(!sys_kind, xtal_en_i, long_tmg_i, por_ext,
                                    BASE_CYC, XTAL_SHORT_CYC, XTAL_LONG_CYC,
                                    STOP_CYC, POR_WAIT_CYC));
  assign cnt_en   = (st == ST_COUNT);
  assign cnt_clr  = sys_hit || stop_hit || (st != ST_COUNT);

  rstseq_ctl u_ctl (
    .clk_i       (clk_i),
    .por_i       (por_i),
    .bor_i       (bor_i),
    .pin_i       (rst_pin_i),
    .stop_wake_i (stop_wake_i),
    .done_i      (cnt_done),
    .state_o     (st),
    .sys_kind_o  (sys_kind),
    .por_ext_o   (por_ext),
    .sys_hit_o   (sys_hit),
    .stop_hit_o  (stop_hit),
    .gpio_o      (gpio_dflt_o)
  );

  rstseq_cnt #(.CW(CW)) u_cnt (
    .clk_i     (clk_i),
    .por_i     (por_i),
    .clr_i     (cnt_clr),
    .en_i      (cnt_en),
    .osc_rdy_i (osc_rdy_i),
    .limit_i   (hold_lim),
    .cnt_o     (cnt_val),
    .done_o    (cnt_done)
  );

  rstseq_cause u_cause (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .sys_hit_i  (sys_hit),
    .bor_i      (bor_i),
    .stop_hit_i (stop_hit),
    .cause_o    (cause_o)
  );

  assign core_rst_o        = (st != ST_RUN);
  assign ctrl_rst_o        = core_rst_o && sys_kind;
  assign rst_pin_drv_low_o = ((st == ST_HOLD) || (st == ST_COUNT)) && sys_kind;

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk
  import rstseq_pkg::*;
#(
  parameter int CW = 14
) (
  input logic          clk_i,
  input logic          por_i,
  input logic          bor_i,
  input logic          rst_pin_i,
  input logic          osc_rdy_i,
  input logic          core_rst_o,
  input logic          ctrl_rst_o,
  input logic          rst_pin_drv_low_o,
  input logic          gpio_dflt_o,
  input logic [3:0]    cause_o,
  input seq_state_e    st,
  input logic [CW-1:0] cnt_val,
  input logic [CW-1:0] hold_lim
);

  assert_ctrl_with_core_R5: assert property (@(posedge clk_i) disable iff (por_i)
    ctrl_rst_o |-> core_rst_o);

  assert_drv_in_sysrst_R8: assert property (@(posedge clk_i) disable iff (por_i)
    rst_pin_drv_low_o |-> (core_rst_o && ctrl_rst_o));

  assert_cause_onehot_R10: assert property (@(posedge clk_i) disable iff (por_i)
    $countones(cause_o) == 1);

  assert_cnt_idle_R6: assert property (@(posedge clk_i) disable iff (por_i)
    !osc_rdy_i |=> (cnt_val == '0));

  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (por_i)
    (st == ST_COUNT) |-> (cnt_val < hold_lim));

  assert_stop_spares_ctrl_R4: assert property (@(posedge clk_i) disable iff (por_i)
    (core_rst_o && cause_o[3]) |-> (!ctrl_rst_o && !rst_pin_drv_low_o));

  assert_pin_stretch_R7: assert property (@(posedge clk_i) disable iff (por_i)
    ((st == ST_PINWAIT) && !rst_pin_i && !bor_i) |=> core_rst_o);

  assert_bor_restart_R11: assert property (@(posedge clk_i) disable iff (por_i)
    bor_i |=> (core_rst_o && cause_o[1] && (st == ST_HOLD)));

  assert_gpio_single_R9: assert property (@(posedge clk_i) disable iff (por_i)
    gpio_dflt_o |=> !gpio_dflt_o);

endmodule

bind rstseq_top rstseq_chk #(.CW(CW)) u_chk (
  .clk_i             (clk_i),
  .por_i             (por_i),
  .bor_i             (bor_i),
  .rst_pin_i         (rst_pin_i),
  .osc_rdy_i         (osc_rdy_i),
  .core_rst_o        (core_rst_o),
  .ctrl_rst_o        (ctrl_rst_o),
  .rst_pin_drv_low_o (rst_pin_drv_low_o),
  .gpio_dflt_o       (gpio_dflt_o),
  .cause_o           (cause_o),
  .st                (st),
  .cnt_val           (cnt_val),
  .hold_lim          (hold_lim)
);

// File: tb/sim_rstseq_top.sv
module sim_rstseq_top;

  localparam int WAIT = 40;

  logic clk = 1'b0;
  logic por = 1'b1, bor = 1'b0, ext_low = 1'b0, wake = 1'b0;
  logic osc = 1'b1, xtal = 1'b0, lng = 1'b0;
  logic core_rst, ctrl_rst, drv_low, gpio;
  logic [3:0] cause;
  logic pin_lvl;

  int n_chk = 0, n_fail = 0, cyc = 0, gpio_hits = 0;
  int m_span, m_ctrl, m_drv;

  always #4 clk = ~clk;

  // Wired-AND reset pin: low if either side pulls it down.
  assign pin_lvl = !(ext_low || drv_low);

  rstseq_top #(.POR_WAIT_CYC(WAIT)) u0 (
    .clk_i(clk), .por_i(por), .bor_i(bor), .rst_pin_i(pin_lvl),
    .stop_wake_i(wake), .osc_rdy_i(osc), .xtal_en_i(xtal), .long_tmg_i(lng),
    .core_rst_o(core_rst), .ctrl_rst_o(ctrl_rst), .rst_pin_drv_low_o(drv_low),
    .gpio_dflt_o(gpio), .cause_o(cause)
  );

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (!por && gpio) gpio_hits <= gpio_hits + 1;

  function automatic int base_len(input logic x, input logic l, input logic p);
    int v;
    case ({x, l})
      2'b10:   v = 568;
      2'b11:   v = 10068;
      default: v = 68;
    endcase
    return p ? v + WAIT : v;
  endfunction

  // Expected core-reset span measured from the trigger release.
  function automatic int exp_span(input logic is_stop, input logic x, input logic l,
                                  input logic p, input int g);
    int extra;
    extra = (g > 1) ? g - 1 : 0;
    if (is_stop) return 4 + extra;
    return base_len(x, l, p) + 1 + extra;
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Called at the release negedge; counts later negedges with core reset high.
  task automatic measure(input int g, input int wake_at);
    int k;
    k = 0; m_span = 0; m_ctrl = 0; m_drv = 0;
    if (g > 0) osc = 1'b0;
    forever begin
      @(negedge clk);
      k++;
      if (k == g) osc = 1'b1;
      wake = (k == wake_at);
      if (!core_rst || k > 20000) break;
      m_span++;
      if (ctrl_rst) m_ctrl++;
      if (drv_low) m_drv++;
    end
    osc = 1'b1;
    wake = 1'b0;
  endtask

  task automatic sys_checks(input string req, input logic p, input int g, input int cz);
    int e;
    e = exp_span(1'b0, xtal, lng, p, g);
    chk(req, "system span", m_span, e);
    chk("R5", "ctrl reset cycles", m_ctrl, e);
    chk("R8", "pin drive cycles", m_drv, e - 1);
    chk("R10", "cause", int'(cause), cz);
  endtask

  task automatic do_bor(input int h, input int g, input string req);
    gpio_hits = 0;
    @(negedge clk); bor = 1'b1;
    repeat (h) @(negedge clk);
    bor = 1'b0;
    measure(g, -1);
    sys_checks(req, 1'b0, g, 2);
    chk("R9", "gpio strobes", gpio_hits, 1);
  endtask

  task automatic do_pin(input int g, input string req);
    gpio_hits = 0;
    @(negedge clk); ext_low = 1'b1;
    @(negedge clk); ext_low = 1'b0;
    measure(g, -1);
    sys_checks(req, 1'b0, g, 4);
    chk("R9", "gpio strobes pin", gpio_hits, 1);
  endtask

  task automatic do_stop(input int g, input int again);
    gpio_hits = 0;
    @(negedge clk); wake = 1'b1;
    measure(g, again);
    chk("R4", "stop span", m_span, (again > 0) ? again + 4 : exp_span(1'b1, xtal, lng, 1'b0, g));
    chk("R4", "ctrl during stop", m_ctrl, 0);
    chk("R8", "pin drive during stop", m_drv, 0);
    chk("R9", "gpio during stop", gpio_hits, 0);
    chk("R10", "cause stop", int'(cause), 8);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: got %0d cycles expected fewer than %0d", cyc, 190000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R2: state while power-on is asserted
    repeat (3) @(negedge clk);
    chk("R2", "core rst in por", int'(core_rst), 1);
    chk("R2", "ctrl rst in por", int'(ctrl_rst), 1);
    chk("R2", "pin drive in por", int'(drv_low), 1);
    chk("R2", "gpio in por", int'(gpio), 1);
    chk("R2", "cause in por", int'(cause), 1);
    por = 1'b0;
    measure(0, -1);
    sys_checks("R2", 1'b1, 0, 1);

    // R1 and R12: brown-out and pin triggers at base length
    do_bor(3, 0, "R1");
    do_pin(0, "R1");
    do_bor(1, 0, "R12");

    // R3: crystal options
    xtal = 1'b1; lng = 1'b0;
    do_bor(2, 0, "R3");
    lng = 1'b1;
    do_pin(0, "R3");
    xtal = 1'b0; lng = 1'b0;

    // R4 and R11: stop recovery, plain and restarted
    do_stop(0, -1);
    do_stop(0, 2);

    // R6: oscillator not ready at the start
    do_bor(2, 25, "R6");
    do_stop(7, -1);

    // R11: wake ignored during a system reset
    @(negedge clk); bor = 1'b1;
    @(negedge clk); bor = 1'b0;
    measure(0, 10);
    chk("R11", "sys span with wake", m_span, exp_span(1'b0, 1'b0, 1'b0, 1'b0, 0));
    chk("R11", "cause after ignored wake", int'(cause), 2);

    // R11: brown-out during stop recovery
    gpio_hits = 0;
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0; bor = 1'b1;
    @(negedge clk);
    chk("R11", "ctrl after bor in stop", int'(ctrl_rst), 1);
    chk("R11", "cause bor in stop", int'(cause), 2);
    chk("R9", "gpio at bor in stop", int'(gpio), 1);
    bor = 1'b0;
    measure(0, -1);
    sys_checks("R11", 1'b0, 0, 2);

    // R7: pin held past expiry
    @(negedge clk); ext_low = 1'b1;
    repeat (68 + 30) @(negedge clk);
    chk("R7", "core held by pin", int'(core_rst), 1);
    chk("R7", "drive released", int'(drv_low), 0);
    ext_low = 1'b0;
    @(negedge clk);
    chk("R7", "core after pin release", int'(core_rst), 0);
    chk("R10", "cause pin", int'(cause), 4);

    // Constrained random mix
    for (int i = 0; i < 30; i++) begin
      int kind, g;
      kind = $urandom_range(2, 0);
      g = ($urandom_range(3, 0) == 0) ? 0 : $urandom_range(6, 1);
      xtal = ($urandom_range(1, 0) == 1);
      lng = xtal && ($urandom_range(3, 0) == 0);
      case (kind)
        0: do_bor($urandom_range(3, 1), g, "R1");
        1: do_pin(g, "R3");
        default: do_stop(g, -1);
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial void'($urandom(32'd1234));

endmodule